// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic stage of an accumulator-style microcontroller datapath. Each request carries the accumulator byte, a second operand byte, a 4-bit operation code and the current 8-bit status word. The block computes the result byte and a new status word. Only the flags that the selected operation is defined to touch are changed. Parity is always recomputed from the result. The status bits the block does not own pass through unchanged.

Requests enter on a valid/ready handshake. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result and status word are registered and presented on the output handshake from the next cycle on. A result stays on the outputs until the consumer takes it on a cycle where `out_valid` and `out_ready` are both high. While the output holds a result that has not been taken and `out_ready` is low, `in_ready` is low, so back-pressure from the consumer reaches the producer within the same cycle. A new request can be accepted on the same edge that an old result is taken, so the block sustains one operation per cycle.

Top module: `acc_alu`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An accepted request gives `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_res` and `out_psw` hold their values.
- R2: Status word layout: carry C in bit 7, auxiliary carry AC in bit 6, overflow OV in bit 2, parity P in bit 0. Bits 5, 4, 3 and 1 of `out_psw` are copied from `in_psw`. Each operation reads its incoming C and AC from `in_psw`.
- R3: Addition, codes 0 (ADD: A+B) and 1 (ADDC: A+B+C). C is the carry out of bit 7. AC is the carry out of bit 3. OV is the carry into bit 7 XOR the carry out of bit 7.
- R4: Subtraction, code 2 (SUBB), gives A−B−C modulo 256. C is the borrow out of bit 7. AC is the borrow out of bit 3. OV is set exactly when the signed result lies outside −128..127.
- R5: Codes 3 AND, 4 OR, 5 XOR, 6 CLR (result 0), 7 CPL (bitwise inverse of A), 8 INC (A+1, wrapping) and 9 DEC (A−1, wrapping). None of them changes C, AC or OV.
- R6: Code 10 rotates A left by one, with bit 7 entering bit 0. Code 11 rotates A right by one, with bit 0 entering bit 7. C, AC and OV are unchanged.
- R7: Code 12 rotates A left through carry: old C enters bit 0 and bit 7 becomes C. Code 13 rotates A right through carry: old C enters bit 7 and bit 0 becomes C. AC and OV are unchanged.
- R8: Code 14 exchanges the upper and lower nibbles of A. Flags are unchanged apart from P.
- R9: Code 15, decimal adjust, works in two steps. First, if the low nibble of A is above 9 or AC is 1, add 6. A carry out of bit 7 from this step sets C. Second, if the high nibble of that sum is above 9 or C is now 1, add 0x60, and a carry out of this step also sets C. C is never cleared. AC and OV are unchanged.
- R10: P in `out_psw` equals the XOR of all bits of `out_res`, so `out_res` and P together hold an even number of ones.
- R11: While `rst_n` is low, `out_valid`, `out_res` and `out_psw` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request this cycle |
| in_op | input | 4 | Operation code (see R3 to R9) |
| in_acc | input | 8 | Accumulator operand |
| in_opnd | input | 8 | Second operand (binary operations only) |
| in_psw | input | 8 | Incoming status word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 8 | Result byte |
| out_psw | output | 8 | Updated status word |

## Verification
A result appears on `out_res` and `out_psw` one cycle after its request is accepted. It then stays there for as many cycles as `out_ready` is held low. The bench drives both handshakes at the falling edge with varying patterns. It lets the signals settle and then decides which transfers the next rising edge will perform. It predicts each accepted request's output at that moment and queues the prediction. The prediction is compared only at the cycle where the output handshake completes, so the check does not depend on how long the result was delayed. On every stalled cycle the bench also checks that the held payload has not changed.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int ALU_W   = 8;
  localparam int NIB_W   = ALU_W / 2;
  localparam int OP_W    = 4;
  localparam int PSW_W   = 8;
  localparam int CY_BIT  = 7;
  localparam int AUX_BIT = 6;
  localparam int OV_BIT  = 2;
  localparam int PAR_BIT = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUBB = 4'd2,  OP_AND  = 4'd3,
    OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_CLR  = 4'd6,  OP_CPL  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_RL   = 4'd10, OP_RR   = 4'd11,
    OP_RLC  = 4'd12, OP_RRC  = 4'd13, OP_SWAP = 4'd14, OP_DA   = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [ALU_W-1:0] res;
    logic [PSW_W-1:0] psw;
  } alu_word_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [ALU_W-1:0] a,
  input  logic [ALU_W-1:0] b,
  input  logic             cin,
  input  logic             sub,
  output logic [ALU_W-1:0] res,
  output logic             cy,
  output logic             aux,
  output logic             ov
);
  // Subtraction runs through the same adder: a + ~b + ~borrow_in.
  logic [ALU_W-1:0] bx;
  logic             ci;
  logic [NIB_W:0]   nib_sum;
  logic [ALU_W-1:0] low_sum;
  logic [ALU_W:0]   full_sum;

  always_comb begin
    bx       = sub ? ~b : b;
    ci       = sub ? ~cin : cin;
    nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, bx[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    low_sum  = {1'b0, a[ALU_W-2:0]} + {1'b0, bx[ALU_W-2:0]} + {{(ALU_W-1){1'b0}}, ci};
    full_sum = {1'b0, a} + {1'b0, bx} + {{ALU_W{1'b0}}, ci};
    res      = full_sum[ALU_W-1:0];
    cy       = sub ? ~full_sum[ALU_W] : full_sum[ALU_W];
    aux      = sub ? ~nib_sum[NIB_W] : nib_sum[NIB_W];
    ov       = full_sum[ALU_W] ^ low_sum[ALU_W-1];
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e          op,
  input  logic [ALU_W-1:0] a,
  input  logic [ALU_W-1:0] b,
  input  logic             cy_in,
  output logic [ALU_W-1:0] res,
  output logic             cy_out
);
  always_comb begin
    res    = a;
    cy_out = cy_in;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_INC:  res = a + ALU_W'(1);
      OP_DEC:  res = a - ALU_W'(1);
      OP_RL:   res = {a[ALU_W-2:0], a[ALU_W-1]};
      OP_RR:   res = {a[0], a[ALU_W-1:1]};
      OP_RLC: begin
        res    = {a[ALU_W-2:0], cy_in};
        cy_out = a[ALU_W-1];
      end
      OP_RRC: begin
        res    = {cy_in, a[ALU_W-1:1]};
        cy_out = a[0];
      end
      OP_SWAP: res = {a[NIB_W-1:0], a[ALU_W-1:NIB_W]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
  import acc_alu_pkg::*;
(
  input  logic [ALU_W-1:0] a,
  input  logic             cy_in,
  input  logic             aux_in,
  output logic [ALU_W-1:0] res,
  output logic             cy_out
);
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [ALU_W:0]   LO_FIX    = (ALU_W+1)'(6);
  localparam logic [ALU_W:0]   HI_FIX    = (ALU_W+1)'(6) << NIB_W;

  logic [ALU_W:0] step1;
  logic [ALU_W:0] step2;
  logic           lo_adj;
  logic           hi_adj;
  logic           cy_mid;

  always_comb begin
    lo_adj = (a[NIB_W-1:0] > DIGIT_MAX) | aux_in;
    step1  = {1'b0, a} + (lo_adj ? LO_FIX : '0);
    cy_mid = cy_in | step1[ALU_W];
    hi_adj = (step1[ALU_W-1:NIB_W] > DIGIT_MAX) | cy_mid;
    step2  = {1'b0, step1[ALU_W-1:0]} + (hi_adj ? HI_FIX : '0);
    res    = step2[ALU_W-1:0];
    cy_out = cy_mid | step2[ALU_W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [ALU_W-1:0] in_acc,
  input  logic [ALU_W-1:0] in_opnd,
  input  logic [PSW_W-1:0] in_psw,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ALU_W-1:0] out_res,
  output logic [PSW_W-1:0] out_psw
);
  alu_op_e          op;
  logic             cy_in, aux_in;
  logic [ALU_W-1:0] as_res, bo_res, da_res;
  logic             as_cy, as_aux, as_ov, bo_cy, da_cy;
  logic             is_sub;
  alu_word_t        nxt, held;
  logic             take_in;

  assign op     = alu_op_e'(in_op);
  assign cy_in  = in_psw[CY_BIT];
  assign aux_in = in_psw[AUX_BIT];
  assign is_sub = (op == OP_SUBB);

  acc_alu_addsub u_addsub (
    .a   (in_acc),
    .b   (in_opnd),
    .cin ((op == OP_ADD) ? 1'b0 : cy_in),
    .sub (is_sub),
    .res (as_res),
    .cy  (as_cy),
    .aux (as_aux),
    .ov  (as_ov)
  );

  acc_alu_bitops u_bitops (
    .op     (op),
    .a      (in_acc),
    .b      (in_opnd),
    .cy_in  (cy_in),
    .res    (bo_res),
    .cy_out (bo_cy)
  );

  acc_alu_decadj u_decadj (
    .a      (in_acc),
    .cy_in  (cy_in),
    .aux_in (aux_in),
    .res    (da_res),
    .cy_out (da_cy)
  );

  always_comb begin
    nxt.psw = in_psw;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nxt.res              = as_res;
        nxt.psw[CY_BIT]      = as_cy;
        nxt.psw[AUX_BIT]     = as_aux;
        nxt.psw[OV_BIT]      = as_ov;
      end
      OP_DA: begin
        nxt.res              = da_res;
        nxt.psw[CY_BIT]      = da_cy;
      end
      default: begin
        nxt.res              = bo_res;
        nxt.psw[CY_BIT]      = bo_cy;
      end
    endcase
    nxt.psw[PAR_BIT] = ^nxt.res;
  end

  assign in_ready = ~out_valid | out_ready;
  assign take_in  = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (take_in) begin
        out_valid <= 1'b1;
        held      <= nxt;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_res = held.res;
  assign out_psw = held.psw;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  in_op,
  input logic [PSW_W-1:0] in_psw,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ALU_W-1:0] out_res,
  input logic [PSW_W-1:0] out_psw
);
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_psw)));

  // R10
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((^{out_res, out_psw[PAR_BIT]}) == 1'b0));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_psw[5:3] == $past(in_psw[5:3]) && out_psw[1] == $past(in_psw[1])));

  // R5
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op >= 4'd3 && in_op <= 4'd9) |=>
      (out_psw[CY_BIT] == $past(in_psw[CY_BIT]) && out_psw[AUX_BIT] == $past(in_psw[AUX_BIT])
       && out_psw[OV_BIT] == $past(in_psw[OV_BIT])));

  // R7
  rot_carry_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == 4'd12 || in_op == 4'd13)) |=>
      (out_psw[AUX_BIT] == $past(in_psw[AUX_BIT]) && out_psw[OV_BIT] == $past(in_psw[OV_BIT])));
endmodule

bind acc_alu acc_alu_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_psw    (in_psw),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_psw   (out_psw)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_acc = '0, in_opnd = '0, in_psw = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_res, out_psw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd), .in_psw(in_psw),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res), .out_psw(out_psw)
  );

  typedef struct { int op; int a; int b; int psw; } req_t;
  typedef struct { int op; int res; int psw; } exp_t;
  req_t stim[$];
  exp_t expq[$];
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] nextrnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic string tag(int op);
    if (op <= 1) return "R3";
    if (op == 2) return "R4";
    if (op <= 9) return "R5";
    if (op <= 11) return "R6";
    if (op <= 13) return "R7";
    if (op == 14) return "R8";
    return "R9";
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Behavioural reference: returns psw*256 + result
  function automatic int model(req_t q);
    int c, ac, ov, r, t, s;
    c = (q.psw >> 7) & 1; ac = (q.psw >> 6) & 1; ov = (q.psw >> 2) & 1;
    r = q.a;
    case (q.op)
      0, 1: begin
        t  = (q.op == 1) ? c : 0;
        s  = q.a + q.b + t;
        r  = s % 256; c = (s > 255);
        ac = ((q.a % 16) + (q.b % 16) + t) > 15;
        s  = sgn(q.a) + sgn(q.b) + t; ov = (s > 127 || s < -128);
      end
      2: begin
        s  = q.a - q.b - c;
        r  = (s + 512) % 256;
        ac = ((q.a % 16) - (q.b % 16) - c) < 0;
        t  = sgn(q.a) - sgn(q.b) - c; ov = (t > 127 || t < -128);
        c  = (s < 0);
      end
      3: r = q.a & q.b;
      4: r = q.a | q.b;
      5: r = q.a ^ q.b;
      6: r = 0;
      7: r = 255 - q.a;
      8: r = (q.a + 1) % 256;
      9: r = (q.a + 255) % 256;
      10: r = ((q.a * 2) % 256) + (q.a / 128);
      11: r = (q.a / 2) + (q.a % 2) * 128;
      12: begin r = ((q.a * 2) % 256) + c; c = q.a / 128; end
      13: begin r = (q.a / 2) + c * 128; c = q.a % 2; end
      14: r = (q.a % 16) * 16 + q.a / 16;
      default: begin
        t = q.a;
        if ((t % 16) > 9 || ac) t = t + 6;
        if (t > 255) c = 1;
        t = t % 256;
        if ((t / 16) > 9 || c) t = t + 96;
        if (t > 255) c = 1;
        r = t % 256;
      end
    endcase
    s = (c << 7) | (ac << 6) | (q.psw & 8'h3A) | (ov << 2) | ($countones(r[7:0]) % 2);
    return s * 256 + r;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
    end
  endtask

  task automatic add(int op, int a, int b);
    req_t q;
    q.op = op; q.a = a; q.b = b; q.psw = int'(nextrnd() & 32'hFF);
    stim.push_back(q);
  endtask

  initial begin
    int idx;
    int m;
    bit stalled;
    logic [7:0] hres, hpsw;
    exp_t e;
    // directed corners first
    add(0, 8'h7F, 8'h01); add(2, 8'h80, 8'h01); add(15, 8'h9A, 8'h00);
    add(15, 8'h99, 8'h00); add(8, 8'hFF, 0); add(9, 8'h00, 0);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 11) begin
        add(0, a, b); add(1, a, b); add(2, a, b);
      end
      for (int b = 0; b < 256; b += 17) begin
        add(3, a, b); add(4, a, b); add(5, a, b);
      end
      for (int k = 0; k < 4; k++)
        for (int op = 6; op < 16; op++) begin
          req_t q;
          q.op = op; q.a = a; q.b = 0;
          q.psw = (k << 6) | int'(nextrnd() & 32'h3F);
          stim.push_back(q);
        end
    end

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
    chk(out_res == 8'h00, "R11", "out_res in reset", out_res, 0);
    chk(out_psw == 8'h00, "R11", "out_psw in reset", out_psw, 0);
    chk(in_ready == 1'b1, "R1", "in_ready when empty", in_ready, 1);
    rst_n = 1'b1;

    idx = 0; stalled = 1'b0; hres = '0; hpsw = '0;
    while (idx < stim.size() || expq.size() > 0 || out_valid) begin
      @(negedge clk);
      if (stalled) begin
        chk(out_valid && out_res == hres && out_psw == hpsw, "R1", "held payload",
            {out_res, out_psw}, {hres, hpsw});
      end
      if (idx < stim.size()) begin
        in_valid = (nextrnd() % 8) != 0;
        in_op = 4'(stim[idx].op); in_acc = 8'(stim[idx].a);
        in_opnd = 8'(stim[idx].b); in_psw = 8'(stim[idx].psw);
      end else in_valid = 1'b0;
      out_ready = (nextrnd() % 4) != 0;
      #1;
      chk(in_ready == (!out_valid || out_ready), "R1", "in_ready", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R1", "unexpected output", 1, 0);
        else begin
          e = expq.pop_front();
          chk(out_res == 8'(e.res), tag(e.op), "result", out_res, e.res);
          chk(out_psw == 8'(e.psw), {tag(e.op), " R2"}, "status word", out_psw, e.psw);
          chk((^{out_res, out_psw[0]}) == 1'b0, "R10", "parity", out_psw[0], ^out_res);
        end
      end
      stalled = out_valid && !out_ready;
      hres = out_res; hpsw = out_psw;
      if (in_valid && in_ready) begin
        m = model(stim[idx]);
        e.op = stim[idx].op; e.res = m % 256; e.psw = m / 256;
        expq.push_back(e);
        idx++;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule